// File: doc/BRIEF.md
# Fully Associative Instruction Line Cache

This block is the storage and lookup core of an instruction cache. It holds a set of 256-bit lines, each tagged with the 15-bit block index taken from fetch address bits [19:5] and guarded by a valid bit. A fetch presented on the lookup port is compared against every valid line at once. On a match the block returns the addressed 32-bit word in the same cycle. The qualification of a fetch as cacheable, the bus protocols and the sequencing of refills all belong to the surrounding logic.

One extra 256-bit shadow buffer sits beside the line array with its own index and valid bit. A line hit copies that whole line into the buffer at the clock edge. The final refill beat of a line also loads the buffer. The buffer is searched in parallel with the lines and takes priority when both match. It never holds data that differs from its source line, so a hit returns the same word whichever copy supplies it.

The block drives a victim line number that the refill logic uses when a miss needs a line. That number is the lowest-numbered invalid line while one exists, and otherwise the least recently used line in true LRU order. Refill beats of 64 bits are written into any chosen line. A single invalidate input drops every valid bit.

Top module: `fa_line_cache`

## Requirements
- R1: After reset no line and no buffer is valid, hit_o is 0 for any lookup, and victim_o is 0.
- R2: hit_o is 1 in the same cycle as a lookup (lookup_en_i = 1) whose address bits [19:5] equal the index of a valid line or of the valid buffer. It is 0 otherwise.
- R3: On a hit, rdata_o is bits [32*k+31 : 32*k] of the matching line, where k is address bits [4:2]. rdata_o is 0 when there is no hit.
- R4: A refill beat (refill_we_i = 1) with beat number b writes refill_data_i to bits [64*b+63 : 64*b] of line refill_line_i and sets that line's index to refill_tag_i. The line becomes valid after a beat with refill_last_i = 1 and is invalid after any other beat, so a partly refilled line never hits.
- R5: A line hit copies the full line into the buffer. Repeating the same lookup in the next cycle, with no refill and no invalidate in between, hits again and returns the same word.
- R6: While any line is invalid, victim_o is the lowest-numbered invalid line. victim_o changes only after a refill beat, an invalidate or a hit.
- R7: When all lines are valid, victim_o is the least recently used line. A hit on a line, or a refill beat into a line, makes that line the most recently used.
- R8: invalidate_i = 1 clears the valid bit of every line and of the buffer at the next edge. This takes priority over a refill last beat in the same cycle. After it, every lookup misses and victim_o is 0.
- R9: When a refill beat and a hitting lookup occur in the same cycle, the lookup still returns its hit and word. Only the refilled line changes its LRU position, and the buffer follows the refill.
- R10: With lookup_en_i = 0, hit_o and rdata_o are 0 and the LRU order is not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lookup_en_i | input | 1 | Lookup request this cycle |
| lookup_addr_i | input | ADDR_W (32) | Fetch byte address; bits [19:5] index, [4:2] word |
| hit_o | output | 1 | Lookup matched a valid line or the buffer |
| rdata_o | output | WORD_W (32) | Selected word on hit, 0 otherwise |
| refill_we_i | input | 1 | Refill beat write strobe |
| refill_line_i | input | log2(NUM_LINES) (6) | Line receiving the beat |
| refill_tag_i | input | IDX_W (15) | Block index of the data being loaded |
| refill_beat_i | input | 2 | 64-bit beat position within the line |
| refill_data_i | input | BEAT_W (64) | Beat data |
| refill_last_i | input | 1 | Final beat; validates the line |
| victim_o | output | log2(NUM_LINES) (6) | Line to use for the next refill |
| invalidate_i | input | 1 | Drop all valid bits |

## Verification
The bench builds the block with NUM_LINES = 8 and leaves every width at its default, so the 256-bit lines, 64-bit beats and 15-bit indexes are the real ones. With only eight lines, a pool of twelve block indexes overfills the store within a few dozen cycles. Every line then reaches the valid state, the selection switches from the invalid-first rule to LRU eviction many times, and the LRU order is reshuffled constantly by hits, refills and lookups that overlap refills. Directed phases cover wrap-ordered beats, partial refills, repeated hits served from the buffer, and an invalidate that lands on a final beat.

// File: rtl/fa_cache_pkg.sv
package fa_cache_pkg;

  // Which copy answers a lookup
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_LINE = 2'd1,
    SRC_BUF  = 2'd2
  } hit_src_e;

endpackage

// File: rtl/fa_tag_match.sv
module fa_tag_match #(
  parameter int unsigned NUM_LINES = 64,
  parameter int unsigned IDX_W     = 15,
  localparam int unsigned LN_W     = $clog2(NUM_LINES)
) (
  input  logic [NUM_LINES-1:0]            valid_i,
  input  logic [NUM_LINES-1:0][IDX_W-1:0] tags_i,
  input  logic [IDX_W-1:0]                key_i,
  output logic                            hit_o,
  output logic [LN_W-1:0]                 hit_idx_o
);

  logic [NUM_LINES-1:0] eq;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_cmp
    assign eq[i] = valid_i[i] && (tags_i[i] == key_i);
  end

  assign hit_o = |eq;

  // lowest matching line wins; at most one is expected to match
  always_comb begin
    hit_idx_o = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (eq[i]) hit_idx_o = LN_W'(i);
    end
  end

endmodule

// File: rtl/fa_lru_ages.sv
module fa_lru_ages #(
  parameter int unsigned NUM_LINES = 64,
  localparam int unsigned LN_W     = $clog2(NUM_LINES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 touch_i,
  input  logic [LN_W-1:0]      touch_idx_i,
  input  logic [NUM_LINES-1:0] valid_i,
  output logic [LN_W-1:0]      victim_o
);

  // age 0 = most recent, NUM_LINES-1 = least recent; ages stay a permutation
  logic [LN_W-1:0] age_q [NUM_LINES];
  logic [LN_W-1:0] touch_age;

  assign touch_age = age_q[touch_idx_i];

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_age
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        age_q[i] <= LN_W'(i);
      end else if (touch_i) begin
        if (touch_idx_i == LN_W'(i))  age_q[i] <= '0;
        else if (age_q[i] < touch_age) age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  logic            any_inv;
  logic [LN_W-1:0] inv_idx;
  logic [LN_W-1:0] lru_idx;

  always_comb begin
    any_inv = 1'b0;
    inv_idx = '0;
    lru_idx = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        any_inv = 1'b1;
        inv_idx = LN_W'(i);
      end
      if (age_q[i] == LN_W'(NUM_LINES - 1)) lru_idx = LN_W'(i);
    end
  end

  assign victim_o = any_inv ? inv_idx : lru_idx;

endmodule

// File: rtl/fa_line_cache.sv
module fa_line_cache
  import fa_cache_pkg::*;
#(
  parameter int unsigned NUM_LINES = 64,
  parameter int unsigned IDX_W     = 15,
  parameter int unsigned LINE_W    = 256,
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned BEAT_W    = 64,
  parameter int unsigned ADDR_W    = 32,
  localparam int unsigned LN_W     = $clog2(NUM_LINES),
  localparam int unsigned BEATS    = LINE_W / BEAT_W,
  localparam int unsigned BSEL_W   = $clog2(BEATS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lookup_en_i,
  input  logic [ADDR_W-1:0] lookup_addr_i,
  output logic              hit_o,
  output logic [WORD_W-1:0] rdata_o,
  input  logic              refill_we_i,
  input  logic [LN_W-1:0]   refill_line_i,
  input  logic [IDX_W-1:0]  refill_tag_i,
  input  logic [BSEL_W-1:0] refill_beat_i,
  input  logic [BEAT_W-1:0] refill_data_i,
  input  logic              refill_last_i,
  output logic [LN_W-1:0]   victim_o,
  input  logic              invalidate_i
);

  localparam int unsigned WORDS  = LINE_W / WORD_W;
  localparam int unsigned WSEL_W = $clog2(WORDS);
  localparam int unsigned OFF_W  = $clog2(LINE_W / 8);
  localparam int unsigned IDX_LO = OFF_W;
  localparam int unsigned IDX_HI = OFF_W + IDX_W - 1;
  localparam int unsigned WSEL_LO = OFF_W - WSEL_W;

  // line store
  logic [NUM_LINES-1:0]            valid_q;
  logic [NUM_LINES-1:0][IDX_W-1:0] tag_q;
  logic [LINE_W-1:0]               data_q [NUM_LINES];

  // shadow buffer
  logic              buf_valid_q;
  logic [IDX_W-1:0]  buf_tag_q;
  logic [LN_W-1:0]   buf_src_q;
  logic [LINE_W-1:0] buf_data_q;

  logic [IDX_W-1:0]  key;
  logic [WSEL_W-1:0] wsel;
  logic              line_hit;
  logic [LN_W-1:0]   line_idx;
  logic              buf_hit;
  hit_src_e          src;
  logic [LINE_W-1:0] sel_line;
  logic [LINE_W-1:0] merged;
  logic              touch;
  logic [LN_W-1:0]   touch_idx;

  logic unused_addr;
  assign unused_addr = ^{lookup_addr_i[ADDR_W-1:IDX_HI+1], lookup_addr_i[WSEL_LO-1:0]};

  assign key  = lookup_addr_i[IDX_HI:IDX_LO];
  assign wsel = lookup_addr_i[OFF_W-1:WSEL_LO];

  fa_tag_match #(
    .NUM_LINES(NUM_LINES),
    .IDX_W    (IDX_W)
  ) u_match (
    .valid_i  (valid_q),
    .tags_i   (tag_q),
    .key_i    (key),
    .hit_o    (line_hit),
    .hit_idx_o(line_idx)
  );

  assign buf_hit = buf_valid_q && (buf_tag_q == key);

  always_comb begin
    if (!lookup_en_i)  src = SRC_NONE;
    else if (buf_hit)  src = SRC_BUF;
    else if (line_hit) src = SRC_LINE;
    else               src = SRC_NONE;
  end

  assign sel_line = (src == SRC_BUF) ? buf_data_q : data_q[line_idx];
  assign hit_o    = (src != SRC_NONE);
  assign rdata_o  = hit_o ? sel_line[wsel*WORD_W +: WORD_W] : '0;

  // refill owns the LRU update when both happen in one cycle
  assign touch     = refill_we_i || hit_o;
  assign touch_idx = refill_we_i      ? refill_line_i :
                     (src == SRC_BUF) ? buf_src_q     : line_idx;

  always_comb begin
    merged = data_q[refill_line_i];
    merged[refill_beat_i*BEAT_W +: BEAT_W] = refill_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      tag_q   <= '0;
    end else begin
      if (refill_we_i) begin
        tag_q[refill_line_i]   <= refill_tag_i;
        valid_q[refill_line_i] <= refill_last_i;
      end
      if (invalidate_i) valid_q <= '0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (refill_we_i) data_q[refill_line_i] <= merged;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_valid_q <= 1'b0;
      buf_tag_q   <= '0;
      buf_src_q   <= '0;
      buf_data_q  <= '0;
    end else begin
      if (refill_we_i) begin
        if (refill_last_i) begin
          buf_valid_q <= 1'b1;
          buf_tag_q   <= refill_tag_i;
          buf_src_q   <= refill_line_i;
          buf_data_q  <= merged;
        end else if (buf_src_q == refill_line_i) begin
          buf_valid_q <= 1'b0;
        end
      end else if (src == SRC_LINE) begin
        buf_valid_q <= 1'b1;
        buf_tag_q   <= key;
        buf_src_q   <= line_idx;
        buf_data_q  <= data_q[line_idx];
      end
      if (invalidate_i) buf_valid_q <= 1'b0;
    end
  end

  fa_lru_ages #(
    .NUM_LINES(NUM_LINES)
  ) u_lru (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .touch_i    (touch),
    .touch_idx_i(touch_idx),
    .valid_i    (valid_q),
    .victim_o   (victim_o)
  );

endmodule

// File: rtl/fa_line_cache_chk.sv
module fa_line_cache_chk #(
  parameter int unsigned NUM_LINES = 64,
  parameter int unsigned IDX_W     = 15,
  parameter int unsigned LINE_W    = 256,
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned ADDR_W    = 32,
  localparam int unsigned LN_W     = $clog2(NUM_LINES),
  localparam int unsigned OFF_W    = $clog2(LINE_W / 8)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              lookup_en_i,
  input logic [ADDR_W-1:0] lookup_addr_i,
  input logic              hit_o,
  input logic [WORD_W-1:0] rdata_o,
  input logic              refill_we_i,
  input logic [IDX_W-1:0]  refill_tag_i,
  input logic              refill_last_i,
  input logic [LN_W-1:0]   victim_o,
  input logic              invalidate_i
);

  logic [IDX_W-1:0] key;
  assign key = lookup_addr_i[OFF_W+IDX_W-1:OFF_W];

  assert_hit_needs_en_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> lookup_en_i);

  assert_inval_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    invalidate_i |=> !hit_o);

  assert_refill_visible_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (refill_we_i && refill_last_i && !invalidate_i)
      |=> (!lookup_en_i || key != $past(refill_tag_i) || hit_o));

  assert_hit_repeats_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && !refill_we_i && !invalidate_i)
      |=> (!lookup_en_i || lookup_addr_i != $past(lookup_addr_i)
           || (hit_o && rdata_o == $past(rdata_o))));

  assert_victim_stable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!refill_we_i && !invalidate_i && !hit_o) |=> $stable(victim_o));

endmodule

bind fa_line_cache fa_line_cache_chk #(
  .NUM_LINES(NUM_LINES),
  .IDX_W    (IDX_W),
  .LINE_W   (LINE_W),
  .WORD_W   (WORD_W),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .lookup_en_i  (lookup_en_i),
  .lookup_addr_i(lookup_addr_i),
  .hit_o        (hit_o),
  .rdata_o      (rdata_o),
  .refill_we_i  (refill_we_i),
  .refill_tag_i (refill_tag_i),
  .refill_last_i(refill_last_i),
  .victim_o     (victim_o),
  .invalidate_i (invalidate_i)
);

// File: tb/tb_fa_line_cache.sv
module tb_fa_line_cache;

  localparam int CLK_PERIOD = 10;
  localparam int NL   = 8;
  localparam int LN_W = 3;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lookup_en_i = 1'b0;
  logic [31:0] lookup_addr_i = '0;
  logic        hit_o;
  logic [31:0] rdata_o;
  logic        refill_we_i = 1'b0;
  logic [LN_W-1:0] refill_line_i = '0;
  logic [14:0] refill_tag_i = '0;
  logic [1:0]  refill_beat_i = '0;
  logic [63:0] refill_data_i = '0;
  logic        refill_last_i = 1'b0;
  logic [LN_W-1:0] victim_o;
  logic        invalidate_i = 1'b0;

  fa_line_cache #(.NUM_LINES(NL)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .lookup_en_i(lookup_en_i), .lookup_addr_i(lookup_addr_i),
    .hit_o(hit_o), .rdata_o(rdata_o),
    .refill_we_i(refill_we_i), .refill_line_i(refill_line_i),
    .refill_tag_i(refill_tag_i), .refill_beat_i(refill_beat_i),
    .refill_data_i(refill_data_i), .refill_last_i(refill_last_i),
    .victim_o(victim_o), .invalidate_i(invalidate_i)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int n_tests = 0;
  int n_fail  = 0;

  // behavioural model: no buffer needed, it always mirrors a valid line
  logic [14:0]  m_tag [NL];
  bit           m_val [NL];
  logic [255:0] m_dat [NL];
  int           lru_q [$];   // front = most recent

  function automatic int m_find(logic [14:0] t);
    for (int i = 0; i < NL; i++) if (m_val[i] && m_tag[i] == t) return i;
    return -1;
  endfunction

  function automatic int m_victim();
    for (int i = 0; i < NL; i++) if (!m_val[i]) return i;
    return lru_q[lru_q.size()-1];
  endfunction

  task automatic m_touch(int l);
    for (int i = 0; i < lru_q.size(); i++) begin
      if (lru_q[i] == l) begin lru_q.delete(i); break; end
    end
    lru_q.push_front(l);
  endtask

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one clock: drive after negedge, compare, then advance the model at the edge
  task automatic cyc(string req, bit en, logic [14:0] tag, int w,
                     bit we, int line, logic [14:0] rtag, int beat,
                     logic [63:0] d, bit last, bit inv);
    int idx;
    bit eh;
    lookup_en_i   = en;
    lookup_addr_i = {12'h2A9, tag, 3'(w), 2'b00};
    refill_we_i   = we;
    refill_line_i = LN_W'(line);
    refill_tag_i  = rtag;
    refill_beat_i = 2'(beat);
    refill_data_i = d;
    refill_last_i = last;
    invalidate_i  = inv;
    #1;
    idx = m_find(tag);
    eh  = en && (idx >= 0);
    chk(req, "hit", 64'(hit_o), 64'(eh));
    chk(req, "rdata", 64'(rdata_o), eh ? 64'(m_dat[idx][w*32 +: 32]) : 64'h0);
    chk(req, "victim", 64'(victim_o), 64'(m_victim()));
    @(posedge clk_i);
    if (we) begin
      m_dat[line][beat*64 +: 64] = d;
      m_tag[line] = rtag;
      m_val[line] = last;
      m_touch(line);
    end else if (eh) begin
      m_touch(idx);
    end
    if (inv) for (int i = 0; i < NL; i++) m_val[i] = 0;
    @(negedge clk_i);
  endtask

  task automatic look(string req, bit en, logic [14:0] tag, int w);
    cyc(req, en, tag, w, 0, 0, '0, 0, '0, 0, 0);
  endtask

  function automatic logic [63:0] beat_data(logic [14:0] t, int b);
    return {16'(t), 16'(b), 32'hC0DE0000 ^ 32'(t * 37 + b)};
  endfunction

  // four beats in wrap order starting at t%4, lookups running alongside
  task automatic fill(string req, logic [14:0] t, int line, bit lk_en, logic [14:0] lk_tag);
    for (int k = 0; k < 4; k++) begin
      int b;
      b = (int'(t) + k) % 4;
      cyc(req, lk_en, lk_tag, k * 2 + 1, 1, line, t, b, beat_data(t, b), k == 3, 0);
    end
  endtask

  initial begin
    repeat (CLK_PERIOD * 150000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < NL; i++) begin m_val[i] = 0; m_tag[i] = '0; m_dat[i] = '0; lru_q.push_back(i); end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1: empty after reset
    look("R1", 1, 15'd20, 0);
    look("R1", 1, 15'd0, 7);

    // R4 R6: fill every line via the invalid-first victim; lookups of the tag being loaded
    for (int t = 20; t < 20 + NL; t++) begin
      fill("R4", 15'(t), m_victim(), 1, 15'(t));
      look("R4", 1, 15'(t), 5);
    end

    // R3: every word of one line
    for (int w = 0; w < 8; w++) look("R3", 1, 15'd22, w);

    // R2: near-miss indexes
    look("R2", 1, 15'd19, 0);
    look("R2", 1, 15'd20 | 15'h4000, 0);

    // R10: matching address with lookup disabled
    look("R10", 0, 15'd21, 3);
    look("R10", 0, 15'd27, 3);

    // R5: back-to-back hits served after the buffer copy
    look("R5", 1, 15'd23, 2);
    look("R5", 1, 15'd23, 2);
    look("R5", 1, 15'd23, 6);

    // R7: reorder, then evict the LRU line
    look("R7", 1, 15'd24, 0);
    look("R7", 1, 15'd20, 0);
    look("R7", 1, 15'd26, 0);
    fill("R7", 15'd30, m_victim(), 0, 15'd0);
    look("R7", 1, 15'd30, 4);
    fill("R7", 15'd31, m_victim(), 0, 15'd0);

    // R9: lookups hitting during a refill do not reorder LRU
    fill("R9", 15'd32, m_victim(), 1, 15'd25);
    fill("R9", 15'd33, m_victim(), 1, 15'd30);
    look("R9", 1, 15'd33, 1);

    // R8: invalidate, then invalidate colliding with a final beat
    cyc("R8", 1, 15'd30, 0, 0, 0, '0, 0, '0, 0, 1);
    look("R8", 1, 15'd30, 0);
    look("R8", 1, 15'd33, 0);
    cyc("R8", 0, 15'd0, 0, 1, 0, 15'd40, 0, beat_data(15'd40, 0), 0, 0);
    cyc("R8", 0, 15'd0, 0, 1, 0, 15'd40, 1, beat_data(15'd40, 1), 0, 0);
    cyc("R8", 0, 15'd0, 0, 1, 0, 15'd40, 2, beat_data(15'd40, 2), 0, 0);
    cyc("R8", 1, 15'd40, 0, 1, 0, 15'd40, 3, beat_data(15'd40, 3), 1, 1);
    look("R8", 1, 15'd40, 0);

    // R2 R7 R9: random traffic over a 12-index pool
    for (int n = 0; n < 1500; n++) begin
      int r;
      logic [14:0] t;
      r = int'($urandom % 16);
      t = 15'(50 + $urandom % 12);
      if (r < 10) begin
        look("R2", ($urandom % 10) != 0, t, int'($urandom % 8));
      end else if (r < 14) begin
        if (m_find(t) < 0) fill("R7", t, m_victim(), 1, 15'(50 + $urandom % 12));
        else look("R5", 1, t, int'($urandom % 8));
      end else if (r == 14) begin
        cyc("R8", 1, t, 0, 0, 0, '0, 0, '0, 0, 1);
      end else begin
        look("R10", 0, t, 0);
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule